// File: doc/BRIEF.md
# Key-Locked Control Register File

This block is a 32-bit control and status register file reached through a single-cycle, word-addressed request port. Every request carries a word offset (the byte address shifted right by two) into a 4 KB window. The decoder puts each offset into one of four classes: read/write, read-only, write-only or unmapped. A bank of ordinary read/write registers is protected by a global write lock. The lock is set after reset.

Software clears the lock by writing a 16-bit unlock key to one offset. It sets the lock again by writing a lock key to a second offset. While the lock is set, writes to ordinary registers are dropped. The lock and unlock offsets always act, whatever the lock state. A one-bit scratch register at offset 0 is exempt from the lock.

Any access that breaks the class of its offset gives a one-cycle error pulse in the same cycle as the request. So does any write that the lock discards. Read data is combinational from registered storage.

Top module: `keylock_regfile`

## Requirements
- R1: After reset, the lock status (offset 0x003, bit 0) reads 1 and the scratch register reads 0. Bank register i (offsets 0x080 to 0x087) reads 0x0001A008 XOR (i × 0x01010101).
- R2: A write to offset 0x001 whose low 16 bits equal 0x767B sets the lock. Bits 31:16 are ignored. Any other value leaves the lock unchanged and raises no error.
- R3: A write to offset 0x002 whose low 16 bits equal 0xDF0D clears the lock. Bits 31:16 are ignored. Any other value leaves the lock unchanged and raises no error.
- R4: While the lock is set, a write to a bank register leaves its stored value unchanged and raises `rsp_err` in the request cycle.
- R5: While the lock is clear, a write to a bank register stores all 32 bits without error. A later read returns them.
- R6: A write to offset 0x000 stores only bit 0 of the data, whether the lock is set or clear, without error. Reads return that bit in bit 0 and zeros above it.
- R7: A write to a read-only offset or to an unmapped offset raises `rsp_err` and changes no storage. The read-only offsets are 0x003 (lock status), 0x040 (PLL status), 0x041 (boot mode) and 0x042 (identity).
- R8: A read of the write-only offsets 0x001 or 0x002, or of an unmapped offset, raises `rsp_err` and returns 0.
- R9: Reads of offsets 0x040, 0x041 and 0x042 return 0x0000003F, 0x00000005 and 0x0A5C0001 without error. Offset 0x003 returns the lock state in bit 0.
- R10: `rsp_err` is only ever high in a cycle with `req_valid` high. A request with `req_valid` low changes no state, even if it carries a valid key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word offset into the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Combinational read data for req_addr |
| rsp_err | output | 1 | Illegal or lock-dropped access, same cycle as request |

## Verification
The assertions take for granted that `rst_n` is held low for at least one clock edge before any request. They also assume the request inputs are stable around each rising edge, because the error pulse and read data are checked combinationally against them. The bench changes inputs only on falling edges and holds reset for several cycles. It walks mapped, unmapped, read-only and write-only offsets in both lock states, including keys that differ from the correct key only in their upper half or by one bit.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam int DATA_W     = 32;
    localparam int KEY_W      = 16;
    localparam int SCRATCH_OFS = 0;
    localparam int LOCK_OFS    = 1;
    localparam int UNLOCK_OFS  = 2;
    localparam int STATUS_OFS  = 3;
    localparam logic [KEY_W-1:0] LOCK_KEY   = 16'h767B;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RO,
        ACC_WO,
        ACC_RW
    } acc_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SCRATCH,
        TGT_LOCK,
        TGT_UNLOCK,
        TGT_STATUS,
        TGT_CONST,
        TGT_BANK
    } tgt_e;

    typedef struct packed {
        acc_e acc;
        tgt_e tgt;
    } dec_t;

endpackage

// File: rtl/keylock_decode.sv
module keylock_decode
    import keylock_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int CONST_BASE = 'h040,
    parameter int N_CONST    = 3,
    parameter int BANK_BASE  = 'h080,
    parameter int N_BANK     = 8,
    localparam int BIDX_W    = (N_BANK > 1) ? $clog2(N_BANK) : 1,
    localparam int CIDX_W    = (N_CONST > 1) ? $clog2(N_CONST) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [BIDX_W-1:0] bank_idx,
    output logic [CIDX_W-1:0] const_idx
);

    localparam int BANK_END  = BANK_BASE + N_BANK;
    localparam int CONST_END = CONST_BASE + N_CONST;

    int a;

    always_comb begin
        a         = int'(addr);
        dec       = '{acc: ACC_NONE, tgt: TGT_NONE};
        bank_idx  = '0;
        const_idx = '0;
        if (a == SCRATCH_OFS) begin
            dec = '{acc: ACC_RW, tgt: TGT_SCRATCH};
        end else if (a == LOCK_OFS) begin
            dec = '{acc: ACC_WO, tgt: TGT_LOCK};
        end else if (a == UNLOCK_OFS) begin
            dec = '{acc: ACC_WO, tgt: TGT_UNLOCK};
        end else if (a == STATUS_OFS) begin
            dec = '{acc: ACC_RO, tgt: TGT_STATUS};
        end else if (a >= CONST_BASE && a < CONST_END) begin
            dec       = '{acc: ACC_RO, tgt: TGT_CONST};
            const_idx = CIDX_W'(a - CONST_BASE);
        end else if (a >= BANK_BASE && a < BANK_END) begin
            dec      = '{acc: ACC_RW, tgt: TGT_BANK};
            bank_idx = BIDX_W'(a - BANK_BASE);
        end
    end

endmodule

// File: rtl/keylock_lock.sv
module keylock_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic locked
);

    typedef struct packed {
        logic locked;
    } lock_t;

    lock_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (set_req) begin
            lock_d.locked = 1'b1;
        end else if (clr_req) begin
            lock_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '{locked: 1'b1};
        end else begin
            lock_q <= lock_d;
        end
    end

    assign locked = lock_q.locked;

endmodule

// File: rtl/keylock_store.sv
module keylock_store #(
    parameter int DW              = 32,
    parameter int N_BANK          = 8,
    parameter logic [DW-1:0] RST_BASE = 32'h0001_A008,
    parameter logic [DW-1:0] RST_STEP = 32'h0101_0101,
    localparam int BIDX_W         = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bank_we,
    input  logic [BIDX_W-1:0]          bank_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic                       scratch_we,
    input  logic                       scratch_bit,
    output logic [N_BANK-1:0][DW-1:0]  bank,
    output logic                       scratch
);

    typedef struct packed {
        logic                      scratch;
        logic [N_BANK-1:0][DW-1:0] regs;
    } store_t;

    function automatic store_t reset_image();
        store_t img;
        img.scratch = 1'b0;
        for (int i = 0; i < N_BANK; i++) begin
            img.regs[i] = RST_BASE ^ (DW'(i) * RST_STEP);
        end
        return img;
    endfunction

    localparam store_t RST_VAL = reset_image();

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (scratch_we) begin
            st_d.scratch = scratch_bit;
        end
        if (bank_we) begin
            st_d.regs[bank_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank    = st_q.regs;
    assign scratch = st_q.scratch;

endmodule

// File: rtl/keylock_regfile.sv
module keylock_regfile
    import keylock_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int N_BANK     = 8,
    parameter int BANK_BASE  = 'h080,
    parameter int CONST_BASE = 'h040,
    parameter logic [31:0] PLL_STAT_VAL = 32'h0000_003F,
    parameter logic [31:0] BOOT_VAL     = 32'h0000_0005,
    parameter logic [31:0] IDENT_VAL    = 32'h0A5C_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);

    localparam int N_CONST = 3;
    localparam int BIDX_W  = (N_BANK > 1) ? $clog2(N_BANK) : 1;
    localparam int CIDX_W  = $clog2(N_CONST);
    localparam logic [N_CONST-1:0][31:0] CONST_VALS = {IDENT_VAL, BOOT_VAL, PLL_STAT_VAL};

    dec_t                          dec;
    logic [BIDX_W-1:0]             bank_idx;
    logic [CIDX_W-1:0]             const_idx;
    logic                          locked;
    logic                          scratch;
    logic [N_BANK-1:0][DATA_W-1:0] bank;
    logic                          wr_req, rd_req;
    logic                          class_bad, lock_drop;
    logic                          set_req, clr_req, bank_we, scratch_we;

    keylock_decode #(
        .ADDR_W(ADDR_W), .CONST_BASE(CONST_BASE), .N_CONST(N_CONST),
        .BANK_BASE(BANK_BASE), .N_BANK(N_BANK)
    ) i_decode (
        .addr(req_addr), .dec(dec), .bank_idx(bank_idx), .const_idx(const_idx)
    );

    always_comb begin
        wr_req     = req_valid && req_write;
        rd_req     = req_valid && !req_write;
        class_bad  = (dec.acc == ACC_NONE)
                   || (req_write && dec.acc == ACC_RO)
                   || (!req_write && dec.acc == ACC_WO);
        lock_drop  = wr_req && locked && dec.tgt == TGT_BANK;
        set_req    = wr_req && dec.tgt == TGT_LOCK && req_wdata[KEY_W-1:0] == LOCK_KEY;
        clr_req    = wr_req && dec.tgt == TGT_UNLOCK && req_wdata[KEY_W-1:0] == UNLOCK_KEY;
        bank_we    = wr_req && !locked && dec.tgt == TGT_BANK;
        scratch_we = wr_req && dec.tgt == TGT_SCRATCH;
        rsp_err    = (req_valid && class_bad) || lock_drop;
    end

    keylock_lock i_lock (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req), .locked(locked)
    );

    keylock_store #(.DW(DATA_W), .N_BANK(N_BANK)) i_store (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_idx(bank_idx),
        .wr_data(req_wdata), .scratch_we(scratch_we), .scratch_bit(req_wdata[0]),
        .bank(bank), .scratch(scratch)
    );

    always_comb begin
        unique case (dec.tgt)
            TGT_SCRATCH: rsp_rdata = {31'b0, scratch};
            TGT_STATUS:  rsp_rdata = {31'b0, locked};
            TGT_CONST:   rsp_rdata = CONST_VALS[const_idx];
            TGT_BANK:    rsp_rdata = bank[bank_idx];
            default:     rsp_rdata = '0;
        endcase
    end

    // R2
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !$past(locked)) |-> $past(req_valid && req_write
            && req_addr == ADDR_W'(LOCK_OFS) && req_wdata[15:0] == 16'h767B));

    // R3
    unlock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && $past(locked)) |-> $past(req_valid && req_write
            && req_addr == ADDR_W'(UNLOCK_OFS) && req_wdata[15:0] == 16'hDF0D));

    // R4
    locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && locked && int'(req_addr) >= BANK_BASE
            && int'(req_addr) < BANK_BASE + N_BANK) |-> rsp_err ##1 $stable(bank));

    // R6
    scratch_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr == ADDR_W'(SCRATCH_OFS)) |-> (rsp_rdata[31:1] == '0 && !rsp_err));

    // R8
    wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr == ADDR_W'(LOCK_OFS)
            || req_addr == ADDR_W'(UNLOCK_OFS))) |-> (rsp_err && rsp_rdata == '0));

    // R10
    err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> req_valid);

endmodule

// File: tb/test_keylock_regfile.sv
module test_keylock_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_lock;
    bit          m_scratch;
    logic [31:0] m_bank [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    keylock_regfile i_keylock_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic bit in_bank(int a);
        return a >= 'h80 && a < 'h80 + NB;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        if (a == 0) return {31'b0, m_scratch};
        if (a == 3) return {31'b0, m_lock};
        if (a == 'h40) return 32'h0000_003F;
        if (a == 'h41) return 32'h0000_0005;
        if (a == 'h42) return 32'h0A5C_0001;
        if (in_bank(a)) return m_bank[a - 'h80];
        return 32'h0;
    endfunction

    function automatic bit exp_err(bit w, int a);
        bit ro, wo, rw;
        ro = (a == 3) || (a >= 'h40 && a <= 'h42);
        wo = (a == 1) || (a == 2);
        rw = (a == 0) || in_bank(a);
        if (!(ro || wo || rw)) return 1;
        if (w && ro) return 1;
        if (!w && wo) return 1;
        if (w && in_bank(a) && m_lock) return 1;
        return 0;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lock = 1;
        m_scratch = 0;
        for (int i = 0; i < NB; i++) m_bank[i] = 32'h0001_A008 ^ (32'(i) * 32'h0101_0101);
    endtask

    task automatic op(bit w, int a, logic [31:0] d, string req);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = 10'(a); req_wdata = d;
        #1;
        check(req, "err", {31'b0, rsp_err}, {31'b0, exp_err(w, a)});
        if (!w) check(req, "rdata", rsp_rdata, exp_read(a));
        @(posedge clk);
        if (w) begin
            if (a == 1 && d[15:0] == 16'h767B) m_lock = 1;
            else if (a == 2 && d[15:0] == 16'hDF0D) m_lock = 0;
            else if (a == 0) m_scratch = d[0];
            else if (in_bank(a) && !m_lock) m_bank[a - 'h80] = d;
        end
    endtask

    task automatic idle(bit w, int a, logic [31:0] d, string req);
        @(negedge clk);
        req_valid = 0; req_write = w; req_addr = 10'(a); req_wdata = d;
        #1;
        check(req, "err idle", {31'b0, rsp_err}, 32'h0);
        @(posedge clk);
    endtask

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        idle(0, 0, 0, "R10");
        // reset state
        op(0, 3, 0, "R1");
        op(0, 0, 0, "R1");
        for (int i = 0; i < NB; i++) op(0, 'h80 + i, 0, "R1");
        // constants
        op(0, 'h40, 0, "R9");
        op(0, 'h41, 0, "R9");
        op(0, 'h42, 0, "R9");
        // locked writes dropped
        op(1, 'h81, 32'h1234_5678, "R4");
        op(0, 'h81, 0, "R4");
        op(1, 'h87, 32'hFFFF_FFFF, "R4");
        op(0, 'h87, 0, "R4");
        // scratch exempt from lock
        op(1, 0, 32'hFFFF_FFFF, "R6");
        op(0, 0, 0, "R6");
        // wrong keys
        op(1, 2, 32'h0000_DF0E, "R3");
        op(0, 3, 0, "R3");
        op(1, 2, 32'h0000_767B, "R3");
        op(0, 3, 0, "R3");
        // masked-valid key on invalid cycle
        idle(1, 2, 32'h0000_DF0D, "R10");
        op(0, 3, 0, "R10");
        // unlock with junk upper half
        op(1, 2, 32'hFFFF_DF0D, "R3");
        op(0, 3, 0, "R3");
        op(0, 'h40, 0, "R9");
        // bank writes unlocked
        for (int i = 0; i < NB; i++) op(1, 'h80 + i, 32'hC0DE_0000 ^ (32'(i) << 4) ^ 32'hA5, "R5");
        for (int i = 0; i < NB; i++) op(0, 'h80 + i, 0, "R5");
        op(1, 'h83, 32'h0, "R5");
        op(0, 'h83, 0, "R5");
        // read-only and unmapped writes
        op(1, 'h40, 32'h0, "R7");
        op(0, 'h40, 0, "R7");
        op(1, 'h42, 32'h1, "R7");
        op(0, 'h42, 0, "R7");
        op(1, 3, 32'h1, "R7");
        op(0, 3, 0, "R7");
        op(1, 'h7F, 32'h1, "R7");
        op(1, 'h88, 32'h1, "R7");
        op(1, 'h3FF, 32'h1, "R7");
        op(0, 'h7F, 0, "R7");
        // illegal reads
        op(0, 1, 0, "R8");
        op(0, 2, 0, "R8");
        op(0, 'h200, 0, "R8");
        op(0, 'h43, 0, "R8");
        // scratch keeps bit 0 only
        op(1, 0, 32'h0000_0002, "R6");
        op(0, 0, 0, "R6");
        op(1, 0, 32'h8000_0001, "R6");
        op(0, 0, 0, "R6");
        // wrong lock key, then lock with junk upper half
        op(1, 1, 32'h0000_767A, "R2");
        op(0, 3, 0, "R2");
        op(1, 1, 32'h1234_767B, "R2");
        op(0, 3, 0, "R2");
        op(1, 'h85, 32'hDEAD_BEEF, "R4");
        op(0, 'h85, 0, "R4");
        op(1, 0, 32'h0, "R6");
        op(0, 0, 0, "R6");
        idle(0, 'h3FF, 0, "R10");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule